// File: doc/BRIEF.md
# Nonlinear Check Error Classification Unit

This unit makes the final decision for a codeword that carries two kinds of protection. The first is a linear multi-error-correcting code. The second is a nonlinear check digit. The unit sits after the linear decoder's error-location stage and handles one codeword at a time. For each codeword it takes two summary inputs from the linear decoder, an error-count indicator and a zero-syndrome flag, together with the located error vector. The codeword and the error vector arrive side by side, one 10-bit digit per clock.

Each codeword is sent in a fixed order:
- the information digits first;
- then the linear redundancy digits;
- then one nonlinear check digit.

When the linear decoder has located errors, the unit XORs the error vector into the received digits. It then streams the repaired digits out. While the information digits pass through, it recomputes the nonlinear function over the repaired information. The nonlinear function is defined as follows:
- consecutive digits are paired;
- the two digits of each pair are multiplied in GF(2^10);
- the products are summed by XOR;
- a fixed mask is added at the end.

At the end of the codeword the unit compares this result with the repaired check digit. A mismatch shows a miscorrection that the linear decoder would have accepted, and it raises the error flag. A done strobe marks the moment the verdict is valid.

Top module: `nlc_classifier`

## Requirements
- R1: When the count latched on the first beat is zero and the syndrome flag is 1 (zero syndrome), the error flag is 0 at done. Every output digit equals its input digit, and the error-vector output is zero on every beat, whatever the error-vector input carries.
- R2: When the latched count is zero and the syndrome flag is 0, the error flag is 1 at done. The data digits pass through unchanged.
- R3: When the latched count has its sign bit set (failure is reported as -1, all ones), the error flag is 1 at done. The data digits pass through unchanged and the error-vector output is zero.
- R4: When the count is positive and every information digit of the error vector is zero, the error flag is 0 at done, even if the check digit does not match. The information digits leave unchanged.
- R5: When the count is positive, each output digit equals input digit XOR error digit. The error-vector output equals the error digit. Both appear one clock after the beat is accepted, with the output valid high.
- R6: When the count is positive and some information error digit is nonzero, the error flag is 0 exactly when f(repaired information) XOR repaired check digit is zero. Here f(d) = MASK XOR the XOR-sum over k of d[2k]·d[2k+1], with the product taken in GF(2^10) modulo x^10+x^3+1.
- R7: The done output pulses high for one cycle, one cycle after the last beat is accepted. This is the same cycle as the last output digit. The error flag holds its value until the next done pulse.
- R8: A codeword has N_INFO information beats, then N_LIN linear redundancy beats, then one check beat. The count and syndrome flag are sampled on the first beat only and ignored on later beats.
- R9: N_INFO must be even. An unpaired information digit still pending at done is reported as an illegal configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Beat strobe for the incoming digit |
| in_data_i | input | 10 | Received codeword digit |
| in_err_i | input | 10 | Located error digit for the same position |
| err_cnt_i | input | CNT_W | Error count from the linear decoder, sampled on the first beat; all ones = failure |
| syn_zero_i | input | 1 | 1 when the linear syndrome is zero, sampled on the first beat |
| out_valid_o | output | 1 | Output digit strobe |
| out_data_o | output | 10 | Repaired or passed-through digit |
| out_err_o | output | 10 | Applied error digit (zero unless the count is positive) |
| done_o | output | 1 | One-cycle pulse when the verdict is valid |
| err_flag_o | output | 1 | 1 = uncorrectable or miscorrected codeword |

## Verification
The bench builds the unit with four information digits, two linear redundancy digits and the mask 0x155. The resulting 7-beat codeword holds two products in the nonlinear sum, so a repair in either pair changes the recomputed check value. This length lets the bench compute the expected check digit by hand-written field arithmetic. With seven beats, several codewords fit in a short run, and the classification cases can be exercised one after another:
- a clean codeword;
- a nonzero syndrome;
- a reported failure;
- errors in the redundancy only;
- a true repair;
- a deliberate miscorrection;
- a check-digit error.

// File: rtl/nlc_pkg.sv
// Package: shared digit width, field arithmetic and verdict classes.
// Assumes GF(2^10) built on x^10 + x^3 + 1.
package nlc_pkg;
    localparam int DIG_W = 10;
    localparam int PROD_W = 2 * DIG_W - 1;
    localparam logic [PROD_W-1:0] FIELD_POLY = PROD_W'(11'h409);

    typedef enum logic [1:0] {
        CLS_CLEAN    = 2'd0,
        CLS_SYNDROME = 2'd1,
        CLS_FAIL     = 2'd2,
        CLS_FIX      = 2'd3
    } verdict_cls_t;

    // Carry-less product followed by top-down polynomial reduction
    function automatic logic [DIG_W-1:0] gf_mul(input logic [DIG_W-1:0] a,
                                                input logic [DIG_W-1:0] b);
        logic [PROD_W-1:0] p;
        p = '0;
        for (int i = 0; i < DIG_W; i++) begin
            if (b[i]) p = p ^ (PROD_W'(a) << i);
        end
        for (int j = PROD_W - 1; j >= DIG_W; j--) begin
            if (p[j]) p = p ^ (FIELD_POLY << (j - DIG_W));
        end
        return p[DIG_W-1:0];
    endfunction
endpackage

// File: rtl/nlc_frame_ctl.sv
// Frame control: tracks the beat position in a codeword, latches the error
// count and syndrome flag on the first beat and classifies the codeword.
// Assumes beats arrive contiguously per codeword (gaps allowed between beats).
module nlc_frame_ctl
    import nlc_pkg::*;
#(
    parameter int N_INFO = 820,
    parameter int N_LIN  = 7,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             syn_zero_i,
    output logic             first_o,
    output logic             in_info_o,
    output logic             odd_o,
    output logic             last_o,
    output verdict_cls_t     cls_o,
    output logic             fix_o
);
    localparam int N_BEAT = N_INFO + N_LIN + 1;
    localparam int PW     = $clog2(N_BEAT);
    localparam logic [PW-1:0] LAST_POS = PW'(N_BEAT - 1);
    localparam logic [PW-1:0] INFO_END = PW'(N_INFO);

    logic [PW-1:0]    pos_q;
    logic [CNT_W-1:0] cnt_q;
    logic             syn_q;
    logic [CNT_W-1:0] cnt_eff;
    logic             syn_eff;

    assign first_o   = (pos_q == '0);
    assign in_info_o = (pos_q < INFO_END);
    assign odd_o     = pos_q[0];
    assign last_o    = (pos_q == LAST_POS);
    assign cnt_eff   = first_o ? cnt_i : cnt_q;
    assign syn_eff   = first_o ? syn_zero_i : syn_q;

    // Classify the codeword from the count and syndrome in force for this beat
    always_comb begin
        if (cnt_eff[CNT_W-1])   cls_o = CLS_FAIL;
        else if (cnt_eff == '0) cls_o = syn_eff ? CLS_CLEAN : CLS_SYNDROME;
        else                    cls_o = CLS_FIX;
    end

    assign fix_o = valid_i && (cls_o == CLS_FIX);

    // Advance the beat position and latch the header on the first beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            cnt_q <= '0;
            syn_q <= 1'b0;
        end else if (valid_i) begin
            pos_q <= last_o ? '0 : pos_q + 1'b1;
            if (first_o) begin
                cnt_q <= cnt_i;
                syn_q <= syn_zero_i;
            end
        end
    end
endmodule

// File: rtl/nlc_nl_accum.sv
// Nonlinear accumulator: pairs consecutive repaired information digits,
// multiplies each pair in GF(2^10) and XOR-accumulates the products. Also
// records whether any information digit was repaired. Assumes an even
// number of information digits starting at beat 0.
module nlc_nl_accum
    import nlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             first_i,
    input  logic             in_info_i,
    input  logic             odd_i,
    input  logic             fix_i,
    input  logic [DIG_W-1:0] corr_i,
    input  logic [DIG_W-1:0] err_i,
    output logic [DIG_W-1:0] acc_o,
    output logic             pend_o,
    output logic             info_hit_o
);
    logic [DIG_W-1:0] buf_q;

    // Buffer the even digit, fold the product in on the odd digit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q      <= '0;
            acc_o      <= '0;
            pend_o     <= 1'b0;
            info_hit_o <= 1'b0;
        end else if (valid_i && in_info_i) begin
            info_hit_o <= (first_i ? 1'b0 : info_hit_o) | (fix_i && (err_i != '0));
            if (!odd_i) begin
                buf_q  <= corr_i;
                pend_o <= 1'b1;
                if (first_i) acc_o <= '0;
            end else begin
                acc_o  <= acc_o ^ gf_mul(buf_q, corr_i);
                pend_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nlc_verdict.sv
// Verdict stage: on the last beat combines the accumulated products, the
// mask and the repaired check digit, and registers the error flag with a
// one-cycle done pulse. The flag holds until the next codeword ends.
module nlc_verdict
    import nlc_pkg::*;
#(
    parameter logic [DIG_W-1:0] MASK = 10'h2A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             last_i,
    input  verdict_cls_t     cls_i,
    input  logic [DIG_W-1:0] acc_i,
    input  logic             info_hit_i,
    input  logic [DIG_W-1:0] corr_i,
    output logic             done_o,
    output logic             err_o
);
    logic [DIG_W-1:0] check;
    logic             decide;

    assign check = acc_i ^ MASK ^ corr_i;

    // Map the class and the recomputed check value to the error flag
    always_comb begin
        unique case (cls_i)
            CLS_CLEAN:    decide = 1'b0;
            CLS_SYNDROME: decide = 1'b1;
            CLS_FAIL:     decide = 1'b1;
            default:      decide = info_hit_i && (check != '0);
        endcase
    end

    // Register the verdict at the end of each codeword
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= valid_i && last_i;
            if (valid_i && last_i) err_o <= decide;
        end
    end
endmodule

// File: rtl/nlc_classifier.sv
// Top: streams a codeword through, applies the located errors when the
// linear decoder reports a positive count, rechecks the nonlinear digit
// and reports the final accept/flag verdict. Assumes N_INFO is even.
module nlc_classifier
    import nlc_pkg::*;
#(
    parameter int               N_INFO = 820,
    parameter int               N_LIN  = 7,
    parameter int               CNT_W  = 4,
    parameter logic [DIG_W-1:0] MASK   = 10'h2A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [DIG_W-1:0] in_data_i,
    input  logic [DIG_W-1:0] in_err_i,
    input  logic [CNT_W-1:0] err_cnt_i,
    input  logic             syn_zero_i,
    output logic             out_valid_o,
    output logic [DIG_W-1:0] out_data_o,
    output logic [DIG_W-1:0] out_err_o,
    output logic             done_o,
    output logic             err_flag_o
);
    logic             first_b;
    logic             in_info_b;
    logic             odd_b;
    logic             last_b;
    logic             fix_b;
    verdict_cls_t     cls_b;
    logic [DIG_W-1:0] applied;
    logic [DIG_W-1:0] corr;
    logic [DIG_W-1:0] acc;
    logic             pend;
    logic             info_hit;

    assign applied = fix_b ? in_err_i : '0;
    assign corr    = in_data_i ^ applied;

    nlc_frame_ctl #(.N_INFO(N_INFO), .N_LIN(N_LIN), .CNT_W(CNT_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .valid_i(in_valid_i),
        .cnt_i(err_cnt_i), .syn_zero_i(syn_zero_i),
        .first_o(first_b), .in_info_o(in_info_b), .odd_o(odd_b),
        .last_o(last_b), .cls_o(cls_b), .fix_o(fix_b)
    );

    nlc_nl_accum acc_i (
        .clk(clk), .rst_n(rst_n), .valid_i(in_valid_i), .first_i(first_b),
        .in_info_i(in_info_b), .odd_i(odd_b), .fix_i(fix_b),
        .corr_i(corr), .err_i(in_err_i),
        .acc_o(acc), .pend_o(pend), .info_hit_o(info_hit)
    );

    nlc_verdict #(.MASK(MASK)) vrd_i (
        .clk(clk), .rst_n(rst_n), .valid_i(in_valid_i), .last_i(last_b),
        .cls_i(cls_b), .acc_i(acc), .info_hit_i(info_hit), .corr_i(corr),
        .done_o(done_o), .err_o(err_flag_o)
    );

    // Register the outgoing digit and the error digit actually applied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
            out_err_o   <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                out_data_o <= corr;
                out_err_o  <= applied;
            end
        end
    end
endmodule

// File: rtl/nlc_classifier_chk.sv
// Checker for nlc_classifier: timing of done, flag stability, pass-through
// and repair of digits, and the even-pairing configuration rule.
module nlc_classifier_chk
    import nlc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid_i,
    input logic [DIG_W-1:0] in_data_i,
    input logic [DIG_W-1:0] in_err_i,
    input logic             out_valid_o,
    input logic [DIG_W-1:0] out_data_o,
    input logic [DIG_W-1:0] out_err_o,
    input logic             done_o,
    input logic             err_flag_o,
    input logic             fix_b,
    input logic             last_b,
    input logic             pend
);
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && last_b) |=> (done_o && out_valid_o)); // R7

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(err_flag_o)); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !fix_b) |=> (out_data_o == $past(in_data_i) && out_err_o == '0)); // R3

    AST_REPAIR_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && fix_b) |=> (out_valid_o && out_data_o == $past(in_data_i ^ in_err_i)
                                    && out_err_o == $past(in_err_i))); // R5

    AST_EVEN_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pend); // R9
endmodule

bind nlc_classifier nlc_classifier_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_err_i(in_err_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_err_o(out_err_o), .done_o(done_o), .err_flag_o(err_flag_o),
    .fix_b(fix_b), .last_b(last_b), .pend(pend)
);

// File: tb/nlc_classifier_tb_top.sv
`timescale 1ns/1ps
module nlc_classifier_tb_top;
    localparam int NI = 4;
    localparam int NL = 2;
    localparam int NB = NI + NL + 1;
    localparam int CW = 4;
    localparam logic [9:0] TB_MASK = 10'h155;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid_i = 1'b0;
    logic [9:0] in_data_i = '0;
    logic [9:0] in_err_i = '0;
    logic [CW-1:0] err_cnt_i = '0;
    logic syn_zero_i = 1'b0;
    logic out_valid_o;
    logic [9:0] out_data_o;
    logic [9:0] out_err_o;
    logic done_o;
    logic err_flag_o;

    int tests_run = 0;
    int tests_failed = 0;

    logic [9:0] fd [NB];
    logic [9:0] fe [NB];
    logic [9:0] obs_d [NB];
    logic [9:0] obs_e [NB];
    int obs_n = 0;
    int done_n = 0;
    int done_at = -1;
    logic done_err = 1'b0;
    logic [9:0] good [NI];

    always #2.5 clk = ~clk;

    nlc_classifier #(.N_INFO(NI), .N_LIN(NL), .CNT_W(CW), .MASK(TB_MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_err_i(in_err_i), .err_cnt_i(err_cnt_i), .syn_zero_i(syn_zero_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_err_o(out_err_o),
        .done_o(done_o), .err_flag_o(err_flag_o)
    );

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid_o && obs_n < NB) begin
                obs_d[obs_n] = out_data_o;
                obs_e[obs_n] = out_err_o;
                obs_n = obs_n + 1;
            end
            if (done_o) begin
                done_n = done_n + 1;
                done_at = obs_n;
                done_err = err_flag_o;
            end
        end
    end

    function automatic logic [9:0] tb_mul(input logic [9:0] a, input logic [9:0] b);
        logic [9:0] r = '0;
        logic [9:0] s = a;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) r = r ^ s;
            s = s[9] ? ((s << 1) ^ 10'h009) : (s << 1);
        end
        return r;
    endfunction

    function automatic logic [9:0] tb_f(input logic [9:0] d0, input logic [9:0] d1,
                                        input logic [9:0] d2, input logic [9:0] d3);
        return tb_mul(d0, d1) ^ tb_mul(d2, d3) ^ TB_MASK;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Load a fresh, consistent codeword into fd with zero error vector
    task automatic load_clean();
        for (int k = 0; k < NI; k++) fd[k] = good[k];
        fd[NI] = 10'h011;
        fd[NI+1] = 10'h222;
        fd[NB-1] = tb_f(good[0], good[1], good[2], good[3]);
        for (int k = 0; k < NB; k++) fe[k] = '0;
    endtask

    // Send fd/fe as one codeword; header only valid on the first beat
    task automatic run_frame(input logic [CW-1:0] cnt, input logic syn,
                             input logic exp_err, input string req);
        bit repair;
        logic [9:0] ed;
        logic [9:0] ee;
        int done_before;
        repair = !cnt[CW-1] && (cnt != '0);
        obs_n = 0;
        done_before = done_n;
        for (int k = 0; k < NB; k++) begin
            @(negedge clk);
            in_valid_i = 1'b1;
            in_data_i = fd[k];
            in_err_i = fe[k];
            err_cnt_i = (k == 0) ? cnt : ~cnt;
            syn_zero_i = (k == 0) ? syn : ~syn;
        end
        @(negedge clk);
        in_valid_i = 1'b0;
        @(negedge clk);
        check(obs_n == NB, {req, " R5 beat count"}, obs_n, NB);
        for (int k = 0; k < NB; k++) begin
            ed = repair ? (fd[k] ^ fe[k]) : fd[k];
            ee = repair ? fe[k] : '0;
            check(obs_d[k] == ed && obs_e[k] == ee, {req, " digit"},
                  {obs_d[k], obs_e[k]}, {ed, ee});
        end
        check(done_n == done_before + 1 && done_at == NB, {req, " R7 done timing"},
              done_at, NB);
        check(done_err == exp_err, {req, " flag"}, done_err, exp_err);
    endtask

    initial begin
        #200000;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        good[0] = 10'h123; good[1] = 10'h2F0; good[2] = 10'h0A5; good[3] = 10'h3C1;
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0 && done_o == 1'b0 && err_flag_o == 1'b0,
              "reset R7", {out_valid_o, done_o, err_flag_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 + R8: clean codeword, stray error digit ignored, later header inverted
        load_clean();
        fe[NI] = 10'h3FF;
        run_frame(4'd0, 1'b1, 1'b0, "R1 R8 clean");

        // R2: zero count but nonzero syndrome
        load_clean();
        run_frame(4'd0, 1'b0, 1'b1, "R2 syndrome");

        // R3: failure indicator, error digits must not be applied
        load_clean();
        fe[1] = 10'h00F;
        run_frame(4'hF, 1'b0, 1'b1, "R3 failure");

        // R4: errors only in redundancy, check digit wrong yet ignored
        load_clean();
        fd[NI] = fd[NI] ^ 10'h081;
        fe[NI] = 10'h081;
        fd[NB-1] = fd[NB-1] ^ 10'h001;
        run_frame(4'd1, 1'b0, 1'b0, "R4 redundancy only");

        // R5 + R6: true repair of two information digits
        load_clean();
        fd[1] = fd[1] ^ 10'h040; fe[1] = 10'h040;
        fd[2] = fd[2] ^ 10'h201; fe[2] = 10'h201;
        run_frame(4'd2, 1'b0, 1'b0, "R5 R6 repair");

        // R6: miscorrection, repaired information inconsistent with check
        load_clean();
        fd[0] = fd[0] ^ 10'h004;
        fe[3] = 10'h004;
        run_frame(4'd1, 1'b0,
                  tb_f(fd[0], fd[1], fd[2], fd[3] ^ 10'h004) != fd[NB-1],
                  "R6 miscorrect");

        // R7: flag holds while idle
        repeat (3) @(negedge clk);
        check(err_flag_o == 1'b1 && done_o == 1'b0, "R7 hold", err_flag_o, 1);

        // R6: information and check digit both repaired
        load_clean();
        fd[0] = fd[0] ^ 10'h100; fe[0] = 10'h100;
        fd[NB-1] = fd[NB-1] ^ 10'h0F0; fe[NB-1] = 10'h0F0;
        run_frame(4'd2, 1'b0, 1'b0, "R6 check digit repair");

        // R9: even pairing exercised via the checker during every frame above
        check(done_n == 7, "R9 frames completed", done_n, 7);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule